// File: doc/BRIEF.md
# Byte Load/Store Execution Unit

This unit carries out single-byte moves between a byte-wide memory port and a bank of 32-bit media registers. It takes one 32-bit instruction word at a time over a valid/ready handshake. From that word it decodes a base general-register index, a signed 8-bit displacement, a media-register index and a lane option. The effective address is the base register plus the sign-extended displacement. Two of the four operations also write that address back into the base register.

A store picks one byte lane out of the media register and writes it to memory. A load fetches one byte and merges it into the chosen lane, and the other three lanes keep their old contents. Lane options above 3 make the instruction a no-op. The same is true of any word outside the unit's operation group. Such words are consumed in a single cycle without touching memory or either register file.

Read ports to the general and media register files are combinational: the index comes from the presented word and the data returns in the same cycle. All outputs toward the register files and memory are registered. Only one operation is in flight at a time.

Top module: `byte_xfer_unit`

## Requirements
- R1: Bits [31:26] of the word must equal GROUP_CODE (default 0x1C). Bits [5:0] then select the operation: 0x22 load, 0x23 store, 0x24 load with base write-back, 0x25 store with base write-back. Any other word is accepted, leaves `instr_ready` high and has no effect on any output.
- R2: Fields: base index in [25:21], lane option in [20:18], displacement in [17:10], media index in [9:6]. The request address equals the base register value plus the displacement sign-extended from 8 bits, taken modulo 2^ADDR_W.
- R3: For 0x24 and 0x25, `gpr_wr_en` pulses for one cycle, in the cycle `mem_req_valid` is high. It carries the base index and the request address. Operations 0x22 and 0x23 never assert it.
- R4: A store with option k in 0..3 issues one request with `mem_req_we`=1 and `mem_req_wdata` = media bits [8k+7:8k]. It completes without waiting for a response and writes no media register.
- R5: A store with option 4..7 issues no memory request and no base write-back.
- R6: A load with option k in 0..3 issues one request with `mem_req_we`=0. In the cycle after `mem_rsp_valid` is sampled, `mreg_wr_en` pulses with the media index. The data is the old media value with bits [8k+7:8k] replaced by `mem_rsp_data`.
- R7: A load with option 4..7 issues no memory request, no base write-back and no media write.
- R8: Media index 0 reads as zero whatever the register file returns. It is never written.
- R9: `instr_ready` is low from the cycle of the memory request until completion. A store completes one cycle after the request. A load completes one cycle after its media write cycle. A response that arrives while no load is waiting is ignored.
- R10: Synchronous active-high reset abandons any operation, raises `instr_ready` and clears every valid and enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Unit can accept a word |
| instr_word | input | 32 | Instruction word |
| gpr_rd_idx | output | 5 | General register read index |
| gpr_rd_data | input | ADDR_W | General register read data |
| gpr_wr_en | output | 1 | Base register write strobe |
| gpr_wr_idx | output | 5 | Base register write index |
| gpr_wr_data | output | ADDR_W | Updated base address |
| mreg_rd_idx | output | 4 | Media register read index |
| mreg_rd_data | input | MREG_W | Media register read data |
| mreg_wr_en | output | 1 | Media register write strobe |
| mreg_wr_idx | output | 4 | Media register write index |
| mreg_wr_data | output | MREG_W | Merged media value |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | LANE_W | Store byte |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_data | input | LANE_W | Loaded byte |

## Verification
The bench uses negative and wrapping displacements, the most negative and most positive offsets, and a base near the top of the address space. These cases expose an adder that zero-extends the displacement or truncates the carry. It sweeps every lane for both directions: a shifted lane select would send or merge the wrong byte, and a whole-word load would clobber the neighbouring lanes. Reserved options on all four operations are driven, since a unit that treats them as lane 0 would write memory or the base register. Media index 0 is driven with a non-zero register-file value, which catches a missing zero override. A stray response while idle and a reset during a pending load catch control that writes a register outside a waiting load.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  // instruction field positions (decoded by the unit)
  localparam int SEL_LSB  = 0;
  localparam int SEL_W    = 6;
  localparam int MIDX_LSB = 6;
  localparam int MIDX_W   = 4;
  localparam int OFF_LSB  = 10;
  localparam int OFF_W    = 8;
  localparam int OPT_LSB  = 18;
  localparam int OPT_W    = 3;
  localparam int BIDX_LSB = 21;
  localparam int BIDX_W   = 5;
  localparam int GRP_LSB  = 26;
  localparam int GRP_W    = 6;
  localparam int WORD_W   = 32;

  localparam logic [SEL_W-1:0] SEL_LOAD    = 6'h22;
  localparam logic [SEL_W-1:0] SEL_STORE   = 6'h23;
  localparam logic [SEL_W-1:0] SEL_LOAD_WB = 6'h24;
  localparam logic [SEL_W-1:0] SEL_STORE_WB = 6'h25;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WB    = 2'd3
  } state_t;

  typedef struct packed {
    logic              act;
    logic              is_load;
    logic              wb;
    logic [MIDX_W-1:0] midx;
    logic [BIDX_W-1:0] bidx;
    logic [OFF_W-1:0]  off;
  } op_t;
endpackage

// File: rtl/bxu_decode.sv
module bxu_decode
  import bxu_pkg::*;
#(
  parameter int LANES      = 4,
  parameter logic [GRP_W-1:0] GROUP_CODE = 6'h1C,
  localparam int LIDX_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word,
  output op_t               op,
  output logic [LIDX_W-1:0] lane
);
  logic [SEL_W-1:0] sel;
  logic [OPT_W-1:0] opt;
  logic             grp_ok;
  logic             known;

  assign sel    = word[SEL_LSB +: SEL_W];
  assign opt    = word[OPT_LSB +: OPT_W];
  assign grp_ok = (word[GRP_LSB +: GRP_W] == GROUP_CODE);

  always_comb begin
    known = 1'b0;
    unique case (sel)
      SEL_LOAD, SEL_STORE, SEL_LOAD_WB, SEL_STORE_WB: known = 1'b1;
      default:                                        known = 1'b0;
    endcase
  end

  always_comb begin
    op.act     = grp_ok && known && (int'(opt) < LANES);
    op.is_load = (sel == SEL_LOAD) || (sel == SEL_LOAD_WB);
    op.wb      = (sel == SEL_LOAD_WB) || (sel == SEL_STORE_WB);
    op.midx    = word[MIDX_LSB +: MIDX_W];
    op.bidx    = word[BIDX_LSB +: BIDX_W];
    op.off     = word[OFF_LSB +: OFF_W];
    lane       = opt[LIDX_W-1:0];
  end
endmodule

// File: rtl/bxu_agen.sv
module bxu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] disp;

  assign disp = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  assign ea   = base + disp;
endmodule

// File: rtl/bxu_pick.sv
module bxu_pick #(
  parameter int MREG_W  = 32,
  parameter int LANE_W  = 8,
  localparam int LANES  = MREG_W / LANE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [MREG_W-1:0] word,
  input  logic [LIDX_W-1:0] lane,
  output logic [LANE_W-1:0] byte_out
);
  always_comb begin
    byte_out = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane == LIDX_W'(i)) byte_out = word[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/bxu_merge.sv
module bxu_merge #(
  parameter int MREG_W  = 32,
  parameter int LANE_W  = 8,
  localparam int LANES  = MREG_W / LANE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [MREG_W-1:0] word,
  input  logic [LIDX_W-1:0] lane,
  input  logic [LANE_W-1:0] byte_in,
  output logic [MREG_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      (lane == LIDX_W'(g)) ? byte_in : word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/byte_xfer_unit.sv
module byte_xfer_unit
  import bxu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MREG_W = 32,
  parameter int LANE_W = 8,
  parameter logic [5:0] GROUP_CODE = 6'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  output logic [4:0]        gpr_rd_idx,
  input  logic [ADDR_W-1:0] gpr_rd_data,
  output logic              gpr_wr_en,
  output logic [4:0]        gpr_wr_idx,
  output logic [ADDR_W-1:0] gpr_wr_data,
  output logic [3:0]        mreg_rd_idx,
  input  logic [MREG_W-1:0] mreg_rd_data,
  output logic              mreg_wr_en,
  output logic [3:0]        mreg_wr_idx,
  output logic [MREG_W-1:0] mreg_wr_data,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LANE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LANE_W-1:0] mem_rsp_data
);
  localparam int LANES  = MREG_W / LANE_W;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  state_t            state;
  op_t               op;
  logic [LIDX_W-1:0] lane;
  logic [ADDR_W-1:0] ea;
  logic [MREG_W-1:0] mrd;
  logic [LANE_W-1:0] picked;
  logic [MREG_W-1:0] merged;

  // operand hold for the pending load
  logic [MREG_W-1:0] held_q;
  logic [LIDX_W-1:0] lane_q;
  logic [MIDX_W-1:0] midx_q;
  logic              load_q;

  bxu_decode #(.LANES(LANES), .GROUP_CODE(GROUP_CODE)) u_decode (
    .word (instr_word),
    .op   (op),
    .lane (lane)
  );

  assign gpr_rd_idx  = op.bidx;
  assign mreg_rd_idx = op.midx;
  assign mrd         = (op.midx == '0) ? '0 : mreg_rd_data;  // index 0 is hard zero
  assign instr_ready = (state == ST_IDLE);

  bxu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base (gpr_rd_data),
    .off  (op.off),
    .ea   (ea)
  );

  bxu_pick #(.MREG_W(MREG_W), .LANE_W(LANE_W)) u_pick (
    .word     (mrd),
    .lane     (lane),
    .byte_out (picked)
  );

  bxu_merge #(.MREG_W(MREG_W), .LANE_W(LANE_W)) u_merge (
    .word    (held_q),
    .lane    (lane_q),
    .byte_in (mem_rsp_data),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      gpr_wr_en     <= 1'b0;
      gpr_wr_idx    <= '0;
      gpr_wr_data   <= '0;
      mreg_wr_en    <= 1'b0;
      mreg_wr_idx   <= '0;
      mreg_wr_data  <= '0;
      held_q        <= '0;
      lane_q        <= '0;
      midx_q        <= '0;
      load_q        <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      gpr_wr_en     <= 1'b0;
      mreg_wr_en    <= 1'b0;
      case (state)
        ST_IDLE: begin
          // inactive words are consumed here without any side effect
          if (instr_valid && op.act) begin
            state         <= ST_ISSUE;
            mem_req_valid <= 1'b1;
            mem_req_we    <= !op.is_load;
            mem_req_addr  <= ea;
            mem_req_wdata <= op.is_load ? '0 : picked;
            gpr_wr_en     <= op.wb;
            gpr_wr_idx    <= op.bidx;
            gpr_wr_data   <= ea;
            held_q        <= mrd;
            lane_q        <= lane;
            midx_q        <= op.midx;
            load_q        <= op.is_load;
          end
        end
        ST_ISSUE: state <= load_q ? ST_WAIT : ST_IDLE;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            state        <= ST_WB;
            mreg_wr_en   <= (midx_q != '0);
            mreg_wr_idx  <= midx_q;
            mreg_wr_data <= merged;
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bxu_checker.sv
module bxu_checker
  import bxu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MREG_W = 32,
  parameter int LANE_W = 8,
  parameter logic [5:0] GROUP_CODE = 6'h1C
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [5:0]        w_grp,
  input logic [5:0]        w_sel,
  input logic [2:0]        w_opt,
  input logic [7:0]        w_off,
  input logic [4:0]        w_bidx,
  input logic [ADDR_W-1:0] gpr_rd_data,
  input logic              gpr_wr_en,
  input logic [4:0]        gpr_wr_idx,
  input logic [ADDR_W-1:0] gpr_wr_data,
  input logic              mreg_wr_en,
  input logic [3:0]        mreg_wr_idx,
  input logic              mem_req_valid,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  localparam int LANES = MREG_W / LANE_W;

  logic              take;
  logic              live;
  logic [ADDR_W-1:0] sx;

  assign take = instr_valid && instr_ready;
  assign live = (w_grp == GROUP_CODE) && (int'(w_opt) < LANES) &&
                (w_sel == SEL_LOAD || w_sel == SEL_STORE ||
                 w_sel == SEL_LOAD_WB || w_sel == SEL_STORE_WB);
  assign sx   = {{(ADDR_W-8){w_off[7]}}, w_off};

  p_busy_at_issue_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !instr_ready);

  p_single_request_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_writeback_with_request_r3: assert property (@(posedge clk) disable iff (rst)
    gpr_wr_en |-> (mem_req_valid && gpr_wr_data == mem_req_addr));

  p_writeback_index_r3: assert property (@(posedge clk) disable iff (rst)
    (take && live) |=> (!gpr_wr_en || gpr_wr_idx == $past(w_bidx)));

  p_effective_address_r2: assert property (@(posedge clk) disable iff (rst)
    (take && live) |=> (mem_req_valid && mem_req_addr == $past(gpr_rd_data + sx)));

  p_inactive_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !live) |=> (!mem_req_valid && !gpr_wr_en && instr_ready));

  p_media_write_after_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    mreg_wr_en |-> $past(mem_rsp_valid));

  p_store_no_media_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |=> (!mreg_wr_en && instr_ready));

  p_zero_index_kept_r8: assert property (@(posedge clk) disable iff (rst)
    mreg_wr_en |-> (mreg_wr_idx != 4'd0));
endmodule

bind byte_xfer_unit bxu_checker #(
  .ADDR_W(ADDR_W), .MREG_W(MREG_W), .LANE_W(LANE_W), .GROUP_CODE(GROUP_CODE)
) i_bxu_checker (
  .clk           (clk),
  .rst           (rst),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .w_grp         (instr_word[31:26]),
  .w_sel         (instr_word[5:0]),
  .w_opt         (instr_word[20:18]),
  .w_off         (instr_word[17:10]),
  .w_bidx        (instr_word[25:21]),
  .gpr_rd_data   (gpr_rd_data),
  .gpr_wr_en     (gpr_wr_en),
  .gpr_wr_idx    (gpr_wr_idx),
  .gpr_wr_data   (gpr_wr_data),
  .mreg_wr_en    (mreg_wr_en),
  .mreg_wr_idx   (mreg_wr_idx),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_byte_xfer_unit.sv
module test_byte_xfer_unit;
  localparam logic [5:0] GRP = 6'h1C;

  typedef struct packed {
    logic [5:0]  sel;
    logic [3:0]  midx;
    logic [7:0]  off;
    logic [2:0]  opt;
    logic [4:0]  bidx;
    logic [31:0] base;
    logic [31:0] mval;
    logic [7:0]  rbyte;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{6'h22, 4'd3,  8'h04, 3'd0, 5'd5,  32'h0000_1000, 32'hA1B2_C3D4, 8'h5E, 2'd0},
    '{6'h22, 4'd7,  8'hFC, 3'd2, 5'd9,  32'h0000_2000, 32'h1122_3344, 8'hAA, 2'd2},
    '{6'h24, 4'd15, 8'h80, 3'd3, 5'd1,  32'h0000_0100, 32'h0000_0000, 8'hFF, 2'd1},
    '{6'h24, 4'd1,  8'h7F, 3'd1, 5'd31, 32'hFFFF_FFF0, 32'h89AB_CDEF, 8'h00, 2'd3},
    '{6'h23, 4'd2,  8'h01, 3'd0, 5'd2,  32'h0000_3000, 32'h0102_0304, 8'h00, 2'd0},
    '{6'h23, 4'd4,  8'h80, 3'd1, 5'd3,  32'h0000_0400, 32'h0102_0304, 8'h00, 2'd0},
    '{6'h25, 4'd5,  8'h10, 3'd2, 5'd4,  32'h0000_0050, 32'hDEAD_BEEF, 8'h00, 2'd0},
    '{6'h25, 4'd6,  8'hF0, 3'd3, 5'd6,  32'h0000_0000, 32'hCAFE_F00D, 8'h00, 2'd0},
    '{6'h23, 4'd2,  8'h08, 3'd4, 5'd7,  32'h0000_5000, 32'h5566_7788, 8'h00, 2'd0},
    '{6'h25, 4'd2,  8'h08, 3'd7, 5'd8,  32'h0000_5000, 32'h5566_7788, 8'h00, 2'd0},
    '{6'h22, 4'd9,  8'h08, 3'd5, 5'd10, 32'h0000_6000, 32'h5566_7788, 8'h99, 2'd0},
    '{6'h24, 4'd9,  8'h08, 3'd6, 5'd11, 32'h0000_6000, 32'h5566_7788, 8'h99, 2'd0},
    '{6'h26, 4'd9,  8'h08, 3'd0, 5'd12, 32'h0000_6000, 32'h5566_7788, 8'h99, 2'd0},
    '{6'h22, 4'd0,  8'h02, 3'd1, 5'd13, 32'h0000_7000, 32'h1234_5678, 8'h77, 2'd1},
    '{6'h23, 4'd0,  8'h03, 3'd3, 5'd14, 32'h0000_7000, 32'hFFFF_FFFF, 8'h00, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [4:0]  gpr_rd_idx;
  logic [31:0] gpr_rd_data = '0;
  logic        gpr_wr_en;
  logic [4:0]  gpr_wr_idx;
  logic [31:0] gpr_wr_data;
  logic [3:0]  mreg_rd_idx;
  logic [31:0] mreg_rd_data = '0;
  logic        mreg_wr_en;
  logic [3:0]  mreg_wr_idx;
  logic [31:0] mreg_wr_data;
  logic        mem_req_valid;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_xfer_unit i_byte_xfer_unit (
    .clk, .rst, .instr_valid, .instr_ready, .instr_word,
    .gpr_rd_idx, .gpr_rd_data, .gpr_wr_en, .gpr_wr_idx, .gpr_wr_data,
    .mreg_rd_idx, .mreg_rd_data, .mreg_wr_en, .mreg_wr_idx, .mreg_wr_data,
    .mem_req_valid, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] word, ea, mv, merged;
    logic [7:0]  sbyte;
    bit ld, wb, known, act;
    word  = {GRP, v.bidx, v.opt, v.off, v.midx, v.sel};
    known = (v.sel >= 6'h22) && (v.sel <= 6'h25);
    act   = known && (v.opt < 3'd4);
    ld    = (v.sel == 6'h22) || (v.sel == 6'h24);
    wb    = (v.sel == 6'h24) || (v.sel == 6'h25);
    ea    = v.base + {{24{v.off[7]}}, v.off};
    mv    = (v.midx == 4'd0) ? 32'h0 : v.mval;
    sbyte = 8'((mv >> (8 * v.opt)) & 32'hFF);
    merged = v.mval;
    if (v.opt < 3'd4) merged[8*v.opt +: 8] = v.rbyte;

    @(negedge clk);
    gpr_rd_data  = v.base;
    mreg_rd_data = v.mval;
    instr_word   = word;
    instr_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    if (!act) begin
      // R1 R5 R7: inactive word leaves every output quiet
      chk("R5/R7 no request", {31'b0, mem_req_valid}, 32'd0);
      chk("R1 no base write", {31'b0, gpr_wr_en}, 32'd0);
      chk("R1 ready kept", {31'b0, instr_ready}, 32'd1);
      @(negedge clk);
      chk("R7 no media write", {31'b0, mreg_wr_en}, 32'd0);
      chk("R5 still no request", {31'b0, mem_req_valid}, 32'd0);
      return;
    end
    chk("R1 request issued", {31'b0, mem_req_valid}, 32'd1);
    chk("R1 direction", {31'b0, mem_req_we}, {31'b0, !ld});
    chk("R2 address", mem_req_addr, ea);
    chk("R3 write-back enable", {31'b0, gpr_wr_en}, {31'b0, wb});
    if (wb) begin
      chk("R3 write-back index", {27'b0, gpr_wr_idx}, {27'b0, v.bidx});
      chk("R3 write-back value", gpr_wr_data, ea);
    end
    chk("R9 busy at issue", {31'b0, instr_ready}, 32'd0);
    if (!ld) begin
      chk("R4 store byte", {24'b0, mem_req_wdata}, {24'b0, sbyte});
      @(negedge clk);
      chk("R4 store done", {31'b0, instr_ready}, 32'd1);
      chk("R4 no media write", {31'b0, mreg_wr_en}, 32'd0);
    end else begin
      @(negedge clk);
      chk("R9 busy waiting", {31'b0, instr_ready}, 32'd0);
      repeat (v.dly) @(negedge clk);
      chk("R6 no early write", {31'b0, mreg_wr_en}, 32'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = v.rbyte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R8/R6 media write enable", {31'b0, mreg_wr_en}, {31'b0, v.midx != 4'd0});
      if (v.midx != 4'd0) begin
        chk("R6 media index", {28'b0, mreg_wr_idx}, {28'b0, v.midx});
        chk("R6 merged value", mreg_wr_data, merged);
      end
      chk("R9 busy in write", {31'b0, instr_ready}, 32'd0);
      @(negedge clk);
      chk("R9 load done", {31'b0, instr_ready}, 32'd1);
      chk("R6 single write", {31'b0, mreg_wr_en}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready in reset", {31'b0, instr_ready}, 32'd1);
    chk("R10 request clear", {31'b0, mem_req_valid}, 32'd0);
    chk("R10 write strobes clear", {30'b0, gpr_wr_en, mreg_wr_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: wrong group code with a load selector
    instr_word  = {6'h00, 5'd2, 3'd0, 8'h00, 4'd3, 6'h22};
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R1 foreign group ignored", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 foreign group ready", {31'b0, instr_ready}, 32'd1);

    // R9: stray response while idle
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 8'h3C;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R9 stray response ignored", {31'b0, mreg_wr_en}, 32'd0);

    // R10: reset during a pending load
    gpr_rd_data  = 32'h0000_0800;
    mreg_rd_data = 32'h0;
    instr_word   = {GRP, 5'd3, 3'd0, 8'h00, 4'd4, 6'h22};
    instr_valid  = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    chk("R10 load pending", {31'b0, instr_ready}, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 ready after abort", {31'b0, instr_ready}, 32'd1);
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R10 aborted load writes nothing", {31'b0, mreg_wr_en}, 32'd0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule